// File: doc/BRIEF.md
# Vector Find-Any-Equal Unit

This block scans a 128-bit source vector A for elements whose value also appears anywhere in a second 128-bit vector B. Elements are 1, 2 or 4 bytes wide. An element of A scores a hit when it matches any element of B at any lane position, not only the lane at the same position. An invert option turns the search into "find an element that appears nowhere in B".

A second, optional search finds the first all-zero element of A. This element acts as a string terminator. The two searches are combined into one of two result forms:
- a per-element mask, in which each element is all ones or all zeros;
- a byte position, which is the earlier of the first hit and the first terminator.

A 2-bit condition code summarises how the two searches relate to each other.

A request is accepted on a cycle with `in_valid` high. The result appears on the registered outputs one cycle later, together with a single-cycle `out_valid` pulse. Between requests the outputs keep their last value.

Top module: `vfind_any_unit`

## Requirements
- R1: `elem_size` selects the element width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The value 3 behaves exactly like 2.
- R2: An element of A is a hit when its value equals any element of B of the same width, at any position in B.
- R3: When `opt_invert` is 1, each element's hit status is complemented before it is used in the mask, the index or the condition code.
- R4: Byte positions count from 0 at `opa[127:120]`. Bytes increase toward the least significant end. The value 16 means "not found". An element's position is that of its first byte.
- R5: When `opt_zero` is 1, the terminator position is the position of the first element of A whose bits are all zero. When `opt_zero` is 0, the terminator position is 16.
- R6: When `opt_mask` is 1, every byte of each result element is 8'hFF if that element is a hit, and 8'h00 if it is not.
- R7: When `opt_mask` is 0, `result[127:64]` holds the smaller of the first-hit position and the terminator position, zero-extended, and `result[63:0]` is zero.
- R8: The condition code `cc` is set as follows, with both positions taken after R3 and R5 and in both result forms:
  - 3 when neither a hit nor a terminator is found;
  - 1 when a hit is found but no terminator;
  - 2 when the first hit lies strictly before the terminator;
  - 0 in all other cases.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `cc` belong to that request.
- R10: A synchronous active-high `rst` clears `out_valid`, `result` and `cc` to zero.
- R11: In a cycle with `in_valid` low, `result` and `cc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 128 | Searched vector A |
| opb | input | 128 | Value set B |
| elem_size | input | 2 | Element width code |
| opt_invert | input | 1 | Complement the hit status |
| opt_mask | input | 1 | 1 = mask result, 0 = index result |
| opt_zero | input | 1 | Enable the terminator search |
| out_valid | output | 1 | Result strobe, one cycle |
| result | output | 128 | Mask or index result |
| cc | output | 2 | Condition code |

## Verification
The bench uses the default `VEC_BYTES` of 16, the only width the element-size codes are defined for. With that width, all three comparator-array variants are generated, and every code from 0 to 3 reaches them. Directed vectors cover several cases:
- matches across lane positions;
- a match that exists only at byte width and disappears when the element widens;
- a terminator that coincides with a hit;
- each of the four condition codes, with and without inversion.

A long run of operands drawn from a four-value byte alphabet then produces dense hits and terminators at every element width.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE  = 2'd0,
    ESZ_HALF  = 2'd1,
    ESZ_WORD  = 2'd2,
    ESZ_ALIAS = 2'd3
  } esz_t;

  localparam int unsigned SIZE_VARIANTS = 3;

  // Map the element-size code onto a comparator-array variant.
  function automatic logic [1:0] size_lane(input logic [1:0] code);
    return (code == ESZ_ALIAS) ? ESZ_WORD : code;
  endfunction

  function automatic int unsigned min_pos(input int unsigned x, input int unsigned y);
    return (x < y) ? x : y;
  endfunction

  // Condition code from the first-hit and terminator positions.
  function automatic logic [1:0] cc_of(input int unsigned hit_pos,
                                       input int unsigned zero_pos,
                                       input int unsigned none_pos);
    if (hit_pos == none_pos && zero_pos == none_pos) return 2'd3;
    if (zero_pos == none_pos)                        return 2'd1;
    if (hit_pos < zero_pos)                          return 2'd2;
    return 2'd0;
  endfunction

endpackage

// File: rtl/vfa_elem_match.sv
// One comparator array for a fixed element width.
module vfa_elem_match #(
  parameter  int VEC_BYTES = 16,
  parameter  int EBYTES    = 1,
  localparam int VW        = 8 * VEC_BYTES
) (
  input  logic [VW-1:0]        vec_a,
  input  logic [VW-1:0]        vec_b,
  output logic [VEC_BYTES-1:0] hit_bytes,
  output logic [VEC_BYTES-1:0] zero_bytes
);

  localparam int NE = VEC_BYTES / EBYTES;
  localparam int EW = 8 * EBYTES;

  logic [NE-1:0] hit_e;
  logic [NE-1:0] zero_e;

  for (genvar i = 0; i < NE; i++) begin : g_a
    logic [EW-1:0] ea;
    logic [NE-1:0] eq;
    assign ea = vec_a[VW-1-i*EW -: EW];
    for (genvar j = 0; j < NE; j++) begin : g_b
      assign eq[j] = (ea == vec_b[VW-1-j*EW -: EW]);
    end
    assign hit_e[i]  = |eq;
    assign zero_e[i] = ~|ea;
  end

  // Byte k carries the flag of the element that contains it.
  for (genvar k = 0; k < VEC_BYTES; k++) begin : g_spread
    assign hit_bytes[k]  = hit_e[k / EBYTES];
    assign zero_bytes[k] = zero_e[k / EBYTES];
  end

endmodule

// File: rtl/vfa_first_index.sv
// Position of the lowest-numbered set flag, or N when none is set.
module vfa_first_index #(
  parameter int N  = 16,
  parameter int IW = 5
) (
  input  logic [N-1:0]  flags,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = IW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (flags[k]) idx = IW'(k);
    end
  end

endmodule

// File: rtl/vfa_result_pack.sv
// Builds the mask or index result and the condition code.
module vfa_result_pack
  import vfa_pkg::*;
#(
  parameter  int VEC_BYTES = 16,
  parameter  int IW        = 5,
  localparam int VW        = 8 * VEC_BYTES,
  localparam int HW        = VW / 2
) (
  input  logic                 mask_mode,
  input  logic [VEC_BYTES-1:0] hit_bytes,
  input  logic [IW-1:0]        hit_idx,
  input  logic [IW-1:0]        zero_idx,
  output logic [VW-1:0]        result_d,
  output logic [1:0]           cc_d
);

  logic [VW-1:0] mask_vec;
  logic [IW-1:0] first_pos;

  for (genvar k = 0; k < VEC_BYTES; k++) begin : g_mask
    assign mask_vec[VW-1-8*k -: 8] = {8{hit_bytes[k]}};
  end

  assign first_pos = IW'(min_pos(int'(hit_idx), int'(zero_idx)));
  assign result_d  = mask_mode ? mask_vec
                               : {{(HW-IW){1'b0}}, first_pos, {HW{1'b0}}};
  assign cc_d      = cc_of(int'(hit_idx), int'(zero_idx), VEC_BYTES);

endmodule

// File: rtl/vfind_any_unit.sv
module vfind_any_unit
  import vfa_pkg::*;
#(
  parameter  int VEC_BYTES = 16,
  localparam int VW        = 8 * VEC_BYTES,
  localparam int IW        = $clog2(VEC_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  input  logic [1:0]    elem_size,
  input  logic          opt_invert,
  input  logic          opt_mask,
  input  logic          opt_zero,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic [1:0]    cc
);

  logic [VEC_BYTES-1:0] hit_v  [SIZE_VARIANTS];
  logic [VEC_BYTES-1:0] zero_v [SIZE_VARIANTS];

  for (genvar s = 0; s < SIZE_VARIANTS; s++) begin : g_size
    vfa_elem_match #(
      .VEC_BYTES(VEC_BYTES),
      .EBYTES   (1 << s)
    ) u_match (
      .vec_a     (opa),
      .vec_b     (opb),
      .hit_bytes (hit_v[s]),
      .zero_bytes(zero_v[s])
    );
  end

  // Named internal events, observed by the checker.
  logic [1:0]           lane;
  logic [VEC_BYTES-1:0] hit_raw;
  logic [VEC_BYTES-1:0] hit_final;
  logic [VEC_BYTES-1:0] zero_flags;
  logic [IW-1:0]        hit_idx;
  logic [IW-1:0]        zero_idx;
  logic [VW-1:0]        result_d;
  logic [1:0]           cc_d;

  assign lane       = size_lane(elem_size);
  assign hit_raw    = hit_v[lane];
  assign hit_final  = opt_invert ? ~hit_raw : hit_raw;
  assign zero_flags = opt_zero ? zero_v[lane] : '0;

  vfa_first_index #(.N(VEC_BYTES), .IW(IW)) u_hit_pos (
    .flags(hit_final),
    .idx  (hit_idx)
  );

  vfa_first_index #(.N(VEC_BYTES), .IW(IW)) u_zero_pos (
    .flags(zero_flags),
    .idx  (zero_idx)
  );

  vfa_result_pack #(.VEC_BYTES(VEC_BYTES), .IW(IW)) u_pack (
    .mask_mode(opt_mask),
    .hit_bytes(hit_final),
    .hit_idx  (hit_idx),
    .zero_idx (zero_idx),
    .result_d (result_d),
    .cc_d     (cc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= result_d;
        cc     <= cc_d;
      end
    end
  end

endmodule

// File: rtl/vfind_any_chk.sv
module vfind_any_chk #(
  parameter  int VEC_BYTES = 16,
  localparam int VW        = 8 * VEC_BYTES,
  localparam int IW        = $clog2(VEC_BYTES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          opt_mask,
  input logic          opt_zero,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic [1:0]    cc,
  input logic [IW-1:0] hit_idx,
  input logic [IW-1:0] zero_idx
);

  function automatic logic bytes_uniform(input logic [VW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < VEC_BYTES; k++) begin
      if (v[8*k +: 8] != 8'h00 && v[8*k +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(cc)));

  a_r7_index_layout: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opt_mask) |=>
      (result[VW/2-1:0] == '0 && result[VW-1:VW/2] <= VEC_BYTES));

  a_r6_mask_uniform: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opt_mask) |=> bytes_uniform(result));

  a_r5_zero_off: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opt_zero) |=> cc[0]);

  a_r8_none: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit_idx == IW'(VEC_BYTES) && zero_idx == IW'(VEC_BYTES))
      |=> (cc == 2'd3));

  a_r8_hit_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit_idx < zero_idx && zero_idx != IW'(VEC_BYTES))
      |=> (cc == 2'd2));

endmodule

bind vfind_any_unit vfind_any_chk #(.VEC_BYTES(VEC_BYTES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .opt_mask (opt_mask),
  .opt_zero (opt_zero),
  .out_valid(out_valid),
  .result   (result),
  .cc       (cc),
  .hit_idx  (hit_idx),
  .zero_idx (zero_idx)
);

// File: tb/vfind_any_unit_tb_top.sv
`timescale 1ns/1ps
module vfind_any_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] opa, opb;
  logic [1:0]   elem_size;
  logic         opt_invert, opt_mask, opt_zero;
  logic         out_valid;
  logic [127:0] result;
  logic [1:0]   cc;

  int checks   = 0;
  int failures = 0;
  logic [127:0] exp_r;
  logic [1:0]   exp_c;

  always #2.5 clk = ~clk;

  vfind_any_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .elem_size(elem_size), .opt_invert(opt_invert), .opt_mask(opt_mask),
    .opt_zero(opt_zero), .out_valid(out_valid), .result(result), .cc(cc)
  );

  function automatic logic [31:0] elem(input logic [127:0] v, input int i, input int eb);
    logic [31:0] x;
    x = 0;
    for (int k = 0; k < eb; k++) x = (x << 8) | 32'(v[127-8*(i*eb+k) -: 8]);
    return x;
  endfunction

  // Behavioural reference model.
  task automatic model(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                       input logic inv, input logic msk, input logic zs,
                       output logic [127:0] r, output logic [1:0] c);
    int eb, ne, fh, fz, m;
    bit h;
    eb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ne = 16 / eb;
    fh = 16; fz = 16;
    r  = '0;
    for (int i = 0; i < ne; i++) begin
      h = 0;
      for (int j = 0; j < ne; j++) if (elem(a, i, eb) == elem(b, j, eb)) h = 1;
      if (inv) h = !h;
      if (h && fh == 16) fh = i * eb;
      if (zs && elem(a, i, eb) == 0 && fz == 16) fz = i * eb;
      if (msk && h)
        for (int k = 0; k < eb; k++) r[127-8*(i*eb+k) -: 8] = 8'hFF;
    end
    m = (fh < fz) ? fh : fz;
    if (!msk) r[127:64] = 64'(m);
    if (fh == 16 && fz == 16)      c = 2'd3;
    else if (fz == 16)             c = 2'd1;
    else if (fh < fz)              c = 2'd2;
    else                           c = 2'd0;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request, checked in the cycle after it is taken.
  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                     input logic inv, input logic msk, input logic zs, input string tag);
    opa = a; opb = b; elem_size = sz; opt_invert = inv; opt_mask = msk; opt_zero = zs;
    in_valid = 1'b1;
    model(a, b, sz, inv, msk, zs, exp_r, exp_c);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 128'(out_valid), 128'd1);
    chk({tag, " result"},  result, exp_r);
    chk({tag, " cc R8"},   128'(cc), 128'(exp_c));
  endtask

  // Idle cycle with junk inputs: outputs must hold.
  task automatic idle(input string tag);
    opa = ~opa; opb = 128'h0; opt_mask = ~opt_mask;
    @(posedge clk); @(negedge clk);
    chk({tag, " R9 no pulse"}, 128'(out_valid), 128'd0);
    chk({tag, " R11 result held"}, result, exp_r);
    chk({tag, " R11 cc held"}, 128'(cc), 128'(exp_c));
  endtask

  localparam logic [127:0] A_TXT = 128'h4142434445464748494A4B4C4D4E4F50;
  localparam logic [127:0] B_NO  = {16{8'h5A}};

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb;
    rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0; elem_size = 2'd0;
    opt_invert = 1'b0; opt_mask = 1'b0; opt_zero = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset result", result, 128'd0);
    chk("R10 reset cc", 128'(cc), 128'd0);
    chk("R10 reset valid", 128'(out_valid), 128'd0);
    rst = 1'b0;
    exp_r = '0; exp_c = 2'd0;

    // R2 R4: A byte 2 equals B byte 15, no terminator -> index 2, cc 1
    run(A_TXT, {B_NO[127:8], 8'h43}, 2'd0, 0, 0, 1, "R2 cross-lane");
    idle("R11 after cross-lane");
    // R8: nothing found -> 16, cc 3
    run(A_TXT, B_NO, 2'd0, 0, 0, 1, "R8 none R4");
    // R8: hit before terminator -> cc 2
    run({A_TXT[127:48], 8'h00, A_TXT[39:0]}, {B_NO[127:8], 8'h43}, 2'd0, 0, 0, 1, "R8 hit first");
    // R8 R5: terminator at byte 1 before hit at byte 5 -> cc 0
    run({8'h41, 8'h00, A_TXT[111:0]}, {8'h46, B_NO[119:0]}, 2'd0, 0, 0, 1, "R5 zero first");
    // R8: terminator element is itself a hit -> cc 0
    run({8'h41, 8'h00, A_TXT[111:0]}, {8'h00, B_NO[119:0]}, 2'd0, 0, 0, 1, "R8 tie");
    // R5: terminator search off, zero present
    run({8'h41, 8'h00, A_TXT[111:0]}, B_NO, 2'd0, 0, 0, 0, "R5 disabled");
    // R3: every A byte present in B except byte 9
    run(A_TXT, {A_TXT[127:56], 8'h5A, A_TXT[47:0]}, 2'd0, 1, 0, 1, "R3 invert");
    run(A_TXT, {B_NO[127:8], 8'h43}, 2'd0, 1, 1, 0, "R3 invert mask R6");
    // R6 mask mode, byte elements
    run({A_TXT[127:8], 8'h00}, {B_NO[127:16], 8'h43, 8'h4F}, 2'd0, 0, 1, 1, "R6 mask byte");
    // R1: byte-level match that vanishes at half width
    run(128'h11223344556677889900AABBCCDDEEFF, {B_NO[127:16], 16'h2233}, 2'd0, 0, 0, 1, "R1 byte");
    run(128'h11223344556677889900AABBCCDDEEFF, {B_NO[127:16], 16'h2233}, 2'd1, 0, 0, 1, "R1 half");
    run(128'h11223344556677889900AABBCCDDEEFF, {B_NO[127:16], 16'h5566}, 2'd1, 0, 1, 1, "R1 half mask R6");
    run(128'h11223344_00000000_99AABBCC_DDEEFF00, {B_NO[127:32], 32'h99AABBCC}, 2'd2, 0, 0, 1, "R1 word R7");
    run(128'h11223344_00000000_99AABBCC_DDEEFF00, {B_NO[127:32], 32'h99AABBCC}, 2'd3, 0, 1, 1, "R1 alias code");
    run(128'h11223344_00000000_99AABBCC_DDEEFF00, {B_NO[127:32], 32'h99AABBCC}, 2'd2, 1, 1, 1, "R3 word invert");
    idle("R11 after word");

    // Dense random operands over a four-value alphabet
    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < 16; k++) begin
        ra[8*k +: 8] = 8'($urandom_range(0, 3));
        rb[8*k +: 8] = 8'($urandom_range(1, 4));
      end
      run(ra, rb, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 random");
      if (t % 7 == 0) idle("R11 random");
    end

    // R10: reset in mid-run clears outputs
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R10 mid reset result", result, 128'd0);
    chk("R10 mid reset cc", 128'(cc), 128'd0);
    chk("R10 mid reset valid", 128'(out_valid), 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule